// File: doc/BRIEF.md
# Image Data Host FIFO with Threshold-Driven DMA Requests

This block buffers image bytes coming from a pixel pipeline and lets an external 8-bit host drain them through an asynchronous strobe port. The port has a single register-select bit. With the select bit low, a write loads the address register and a read returns a status byte. With the select bit high, the host reaches a small set of local registers through the address register: the FIFO data byte, the fill count, the threshold, a control byte, an interrupt mask and an error clear.

Two outputs ask the host for service. A level interrupt tracks the threshold comparison and the error flag, each gated by a mask bit. A DMA request rises when the fill count reaches the threshold and falls as soon as the first byte of the burst is taken. It rises again only after the whole burst has been read. Each frame start flushes anything left over from the previous frame and flags it. Writes into a full buffer are dropped and flagged in the same way.

The host strobes are asynchronous, so each one is passed through a two-flop synchronizer. A read or write takes effect on the core-clock cycle in which the synchronized strobe is seen to go active. Host read data is registered at that moment and held until the next read.

Top module: `hfifo_host_if`

## Requirements
- R1: After reset the fill count is 0, the status byte reads 0x04 (empty only), `host_dout` is 0x00, `host_irq` is low and `host_drq` is low.
- R2: Bytes read through the data register at local address 0 come out in the order they were pushed on `px_data`. The count register (local address 1 = bits 7:0, address 2 = upper bits) reports the number of bytes held.
- R3: The buffer holds DEPTH (default 2048) bytes. A push while it is full is dropped, the count stays at DEPTH, and error flag status bit 1 is set. Status bit 3 reports full.
- R4: A data read while the buffer is empty returns the last byte validly read and leaves the count at 0.
- R5: A `frame_start` pulse empties the buffer. It sets the error flag when at least one byte was discarded and leaves the flag unchanged when the buffer was already empty.
- R6: Writing a value with bit 0 set to local address 7 clears the error flag.
- R7: `host_irq` is high while (mask bit 0 and count >= threshold) or (mask bit 1 and error flag), with the mask at local address 6. It drops once a read takes the count below the threshold. Status bit 0 reports count >= threshold.
- R8: The internal DMA request sets when count >= threshold (threshold at local addresses 3 and 4, reset value 16). It clears after the first data read of a burst and stays clear until the burst has been read out. Control bits 1:0 at local address 5 select the burst length: 0 = 8, 1 = 16, 2 or 3 = 32 bytes. Status bit 4 shows the raw request.
- R9: Control bit 2 set makes `host_drq` active-low. When clear, `host_drq` is active-high.
- R10: The 16-bit address register is loaded by two select-low writes, low byte first. Any read returns the sequence to the low byte. Only address bits 2:0 are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_valid | input | 1 | Image byte push strobe |
| px_data | input | 8 | Image byte |
| frame_start | input | 1 | One-cycle pulse at the start of a frame envelope |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_rs | input | 1 | Register select: 0 address/status, 1 data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data, updated when a read is detected |
| host_irq | output | 1 | Level interrupt request |
| host_drq | output | 1 | DMA request, polarity set by control bit 2 |

## Verification
A wrong fill count shows up at the ports almost at once, within two or three core cycles of a push or pop. It appears as a wrong threshold status bit, an early or late interrupt, or a DMA request in the wrong cycle, and on the next read of the count register. Corrupt pointers show up on the very next data read as a byte out of order against the expected stream. A stuck burst counter shows up as a DMA request that fails to rise again once a burst has been read. A broken address-byte sequence selects the wrong local register, so the next data read returns the wrong register value.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

  typedef enum logic [2:0] {
    LOC_DATA   = 3'd0,
    LOC_CNT_LO = 3'd1,
    LOC_CNT_HI = 3'd2,
    LOC_THR_LO = 3'd3,
    LOC_THR_HI = 3'd4,
    LOC_CTRL   = 3'd5,
    LOC_MASK   = 3'd6,
    LOC_CLEAR  = 3'd7
  } loc_reg_e;

  localparam int BURST_W = 6;

  function automatic logic [BURST_W-1:0] burst_len(input logic [1:0] sel);
    case (sel)
      2'd0:    burst_len = BURST_W'(8);
      2'd1:    burst_len = BURST_W'(16);
      default: burst_len = BURST_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/hfifo_strobe_sync.sv
module hfifo_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic strobe_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= strobe_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign strobe_rise = sync_q & ~prev_q;
endmodule

// File: rtl/hfifo_store.sv
module hfifo_store #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          ovf_evt,
  output logic          discard_evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // after a flush the buffer is empty, so a push in the same cycle always fits
  assign push_ok     = push & (flush | ~full);
  assign pop_ok      = pop & ~empty & ~flush;
  assign ovf_evt     = push & full & ~flush;
  assign discard_evt = flush & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end
    if (pop_ok) begin
      rd_ptr_d = rd_ptr_q + AW'(1);
      cnt_d    = cnt_d - CW'(1);
    end
    if (push_ok) begin
      wr_ptr_d = wr_ptr_d + AW'(1);
      cnt_d    = cnt_d + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage array carries no reset; the write address follows the flush
  logic [AW-1:0] wr_addr;
  assign wr_addr = flush ? '0 : wr_ptr_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_addr] <= push_data;
  end

  assign head_data = mem[rd_ptr_q];
  assign count     = cnt_q;
endmodule

// File: rtl/hfifo_dreq.sv
module hfifo_dreq
  import hfifo_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thresh,
  input  logic [1:0]    burst_sel,
  input  logic          pop,
  input  logic          flush,
  output logic          req
);
  logic               req_q, req_d;
  logic [BURST_W-1:0] left_q, left_d;

  always_comb begin
    req_d  = req_q;
    left_d = left_q;
    if (flush) begin
      req_d  = 1'b0;
      left_d = '0;
    end else if (req_q && pop) begin
      req_d  = 1'b0;
      left_d = burst_len(burst_sel) - BURST_W'(1);
    end else if (left_q != '0) begin
      req_d = 1'b0;
      if (pop) left_d = left_q - BURST_W'(1);
    end else begin
      req_d = (count >= thresh);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      left_q <= '0;
    end else begin
      req_q  <= req_d;
      left_q <= left_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/hfifo_host_if.sv
module hfifo_host_if
  import hfifo_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int THR_RESET = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       px_valid,
  input  logic [7:0] px_data,
  input  logic       frame_start,
  input  logic       host_cs_n,
  input  logic       host_rd_n,
  input  logic       host_wr_n,
  input  logic       host_rs,
  input  logic [7:0] host_din,
  output logic [7:0] host_dout,
  output logic       host_irq,
  output logic       host_drq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int HW = CW - 8;

  logic          rd_evt, wr_evt;
  logic [7:0]    head_data;
  logic [CW-1:0] count;
  logic          empty, full, ovf_evt, discard_evt;
  logic          fifo_rd, drq_req, thr_hit;

  logic [15:0]   addr_q, addr_d;
  logic          addr_hi_q, addr_hi_d;
  logic [CW-1:0] thr_q, thr_d;
  logic [7:0]    ctrl_q, ctrl_d;
  logic [1:0]    mask_q, mask_d;
  logic          err_q, err_d;
  logic [7:0]    dout_q, dout_d;
  logic [7:0]    last_q, last_d;
  logic          last_en, dout_en;
  loc_reg_e      loc;
  logic [7:0]    status;

  hfifo_strobe_sync u_rd_sync (
    .clk(clk), .rst_n(rst_n),
    .strobe_async(~(host_cs_n | host_rd_n)), .strobe_rise(rd_evt)
  );

  hfifo_strobe_sync u_wr_sync (
    .clk(clk), .rst_n(rst_n),
    .strobe_async(~(host_cs_n | host_wr_n)), .strobe_rise(wr_evt)
  );

  assign loc     = loc_reg_e'(addr_q[2:0]);
  assign fifo_rd = rd_evt & host_rs & (loc == LOC_DATA);

  hfifo_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(px_valid), .push_data(px_data),
    .pop(fifo_rd), .flush(frame_start),
    .head_data(head_data), .count(count),
    .empty(empty), .full(full),
    .ovf_evt(ovf_evt), .discard_evt(discard_evt)
  );

  hfifo_dreq #(.CW(CW)) u_dreq (
    .clk(clk), .rst_n(rst_n),
    .count(count), .thresh(thr_q), .burst_sel(ctrl_q[1:0]),
    .pop(fifo_rd), .flush(frame_start), .req(drq_req)
  );

  assign thr_hit = (count >= thr_q);
  assign status  = {3'b000, drq_req, full, empty, err_q, thr_hit};

  // host write path
  always_comb begin
    addr_d    = addr_q;
    addr_hi_d = addr_hi_q;
    thr_d     = thr_q;
    ctrl_d    = ctrl_q;
    mask_d    = mask_q;
    if (rd_evt) addr_hi_d = 1'b0;
    if (wr_evt && !host_rs) begin
      if (addr_hi_q) addr_d[15:8] = host_din;
      else           addr_d[7:0]  = host_din;
      addr_hi_d = ~addr_hi_q;
    end else if (wr_evt) begin
      case (loc)
        LOC_THR_LO: thr_d[7:0]    = host_din;
        LOC_THR_HI: thr_d[CW-1:8] = host_din[HW-1:0];
        LOC_CTRL:   ctrl_d        = host_din;
        LOC_MASK:   mask_d        = host_din[1:0];
        default: ;
      endcase
    end
  end

  // error flag: a new error wins over a clear in the same cycle
  always_comb begin
    err_d = err_q;
    if (wr_evt && host_rs && (loc == LOC_CLEAR) && host_din[0]) err_d = 1'b0;
    if (ovf_evt || discard_evt) err_d = 1'b1;
  end

  // host read path
  always_comb begin
    dout_d  = dout_q;
    last_d  = last_q;
    dout_en = rd_evt;
    last_en = fifo_rd & ~empty & ~frame_start;
    if (!host_rs) begin
      dout_d = status;
    end else begin
      case (loc)
        LOC_DATA:   dout_d = last_en ? head_data : last_q;
        LOC_CNT_LO: dout_d = count[7:0];
        LOC_CNT_HI: dout_d = 8'(count[CW-1:8]);
        LOC_THR_LO: dout_d = thr_q[7:0];
        LOC_THR_HI: dout_d = 8'(thr_q[CW-1:8]);
        LOC_CTRL:   dout_d = ctrl_q;
        LOC_MASK:   dout_d = {6'b0, mask_q};
        default:    dout_d = 8'h00;
      endcase
    end
    if (last_en) last_d = head_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      addr_hi_q <= 1'b0;
      thr_q     <= CW'(THR_RESET);
      ctrl_q    <= '0;
      mask_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      addr_q    <= addr_d;
      addr_hi_q <= addr_hi_d;
      thr_q     <= thr_d;
      ctrl_q    <= ctrl_d;
      mask_q    <= mask_d;
      err_q     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      last_q <= '0;
    end else begin
      if (dout_en) dout_q <= dout_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign host_dout = dout_q;
  assign host_irq  = (mask_q[0] & thr_hit) | (mask_q[1] & err_q);
  assign host_drq  = drq_req ^ ctrl_q[2];
endmodule

// File: rtl/hfifo_host_if_chk.sv
module hfifo_host_if_chk #(
  parameter int DEPTH = 2048,
  parameter int CW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          px_valid,
  input logic          frame_start,
  input logic          fifo_rd,
  input logic [CW-1:0] count,
  input logic          empty,
  input logic          full,
  input logic          err_q,
  input logic          drq_req,
  input logic [1:0]    mask_q,
  input logic          host_irq
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && full && !frame_start) |=> err_q); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && full && !frame_start && !fifo_rd) |=> (count == CW'(DEPTH))); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && empty && !px_valid && !frame_start) |=> $stable(count)); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !px_valid) |=> (count == '0)); // R5
  AST_FLUSH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !empty) |=> err_q); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b00) |-> !host_irq); // R7
  AST_DRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (drq_req && fifo_rd && !empty && !frame_start) |=> !drq_req); // R8
endmodule

bind hfifo_host_if hfifo_host_if_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .frame_start(frame_start),
  .fifo_rd(fifo_rd), .count(count), .empty(empty), .full(full),
  .err_q(err_q), .drq_req(drq_req), .mask_q(mask_q), .host_irq(host_irq)
);

// File: tb/hfifo_host_if_bench.sv
module hfifo_host_if_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       px_valid = 1'b0;
  logic [7:0] px_data = '0;
  logic       frame_start = 1'b0;
  logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_rs = 1'b0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;
  logic       host_irq, host_drq;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_exp = '0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  hfifo_host_if u_hfifo_host_if (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); px_valid = 1'b1; px_data = d;
    if (exp_q.size() < 2048) exp_q.push_back(d);
    @(negedge clk); px_valid = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    exp_q.delete();
    @(negedge clk); frame_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_wr(input logic rs, input logic [7:0] d);
    @(negedge clk); host_rs = rs; host_din = d; host_cs_n = 1'b0; host_wr_n = 1'b0;
    repeat (8) @(negedge clk);
    host_wr_n = 1'b1; host_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_rd(input logic rs, output logic [7:0] d);
    @(negedge clk); host_rs = rs; host_cs_n = 1'b0; host_rd_n = 1'b0;
    repeat (8) @(negedge clk);
    d = host_dout;
    host_rd_n = 1'b1; host_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_addr(input logic [15:0] a);
    host_wr(1'b0, a[7:0]);
    host_wr(1'b0, a[15:8]);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    set_addr({13'h0, a});
    host_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    set_addr({13'h0, a});
    host_rd(1'b1, d);
  endtask

  // scoreboard monitor: pops the expected byte for each data read
  task automatic fifo_read_check(input string req);
    logic [7:0] e;
    host_rd(1'b1, rv);
    if (exp_q.size() > 0) e = exp_q.pop_front(); else e = last_exp;
    last_exp = e;
    check(req, rv, e);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 dout", host_dout, 8'h00);
    check("R1 irq", host_irq, 0);
    check("R1 drq", host_drq, 0);
    host_rd(1'b0, rv); check("R1 status", rv, 8'h04);
    reg_rd(3'd1, rv); check("R1 count", rv, 0);

    // R2 ordering and count
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    reg_rd(3'd1, rv); check("R2 count lo", rv, 5);
    set_addr(16'h0000);
    for (int i = 0; i < 5; i++) fifo_read_check("R2 order");
    // R4 empty read replays last
    fifo_read_check("R4 replay");
    host_rd(1'b0, rv); check("R4 status empty", rv, 8'h04);

    // R10 address byte sequence reset by read
    reg_wr(3'd5, 8'h01);
    host_wr(1'b0, 8'h03);
    host_rd(1'b0, rv);
    host_wr(1'b0, 8'h05);
    host_rd(1'b1, rv); check("R10 addr low after read", rv, 8'h01);
    reg_wr(3'd5, 8'h00);

    // R7 / R8 threshold, irq, drq
    reg_wr(3'd3, 8'd8);
    reg_wr(3'd4, 8'd0);
    reg_wr(3'd6, 8'h01);
    for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
    repeat (3) @(negedge clk);
    check("R7 irq below thr", host_irq, 0);
    check("R8 drq below thr", host_drq, 0);
    push(8'h17);
    repeat (3) @(negedge clk);
    check("R7 irq at thr", host_irq, 1);
    check("R8 drq at thr", host_drq, 1);
    set_addr(16'h0000);
    fifo_read_check("R2 order thr");
    check("R7 irq released", host_irq, 0);
    check("R8 drq drop after first", host_drq, 0);
    for (int i = 0; i < 13; i++) push(8'h20 + 8'(i));
    repeat (3) @(negedge clk);
    check("R8 drq held in burst", host_drq, 0);
    for (int i = 0; i < 7; i++) fifo_read_check("R2 order burst");
    check("R8 drq rearm", host_drq, 1);
    host_rd(1'b0, rv); check("R8 status", rv, 8'h11);
    // R9 polarity
    reg_wr(3'd5, 8'h04);
    repeat (2) @(negedge clk);
    check("R9 drq active low", host_drq, 0);
    reg_wr(3'd5, 8'h00);
    repeat (2) @(negedge clk);
    check("R9 drq active high", host_drq, 1);

    // R5 flush with leftovers
    frame();
    host_rd(1'b0, rv); check("R5 flush err", rv, 8'h06);
    check("R5 drq cleared", host_drq, 0);
    reg_wr(3'd6, 8'h03);
    repeat (2) @(negedge clk);
    check("R7 irq from err", host_irq, 1);
    // R6 clear
    reg_wr(3'd7, 8'h01);
    repeat (2) @(negedge clk);
    check("R6 irq after clear", host_irq, 0);
    host_rd(1'b0, rv); check("R6 status", rv, 8'h04);
    frame();
    host_rd(1'b0, rv); check("R5 empty flush no err", rv, 8'h04);

    // R3 full and overflow
    reg_wr(3'd6, 8'h00);
    reg_wr(3'd3, 8'hF0);
    reg_wr(3'd4, 8'h07);
    @(negedge clk);
    px_valid = 1'b1;
    for (int i = 0; i < 2050; i++) begin
      px_data = 8'(i) ^ 8'h5A;
      if (i < 2048) exp_q.push_back(px_data);
      @(negedge clk);
    end
    px_valid = 1'b0;
    reg_rd(3'd1, rv); check("R3 count lo", rv, 8'h00);
    reg_rd(3'd2, rv); check("R3 count hi", rv, 8'h08);
    host_rd(1'b0, rv); check("R3 status full err", rv, 8'h1B);
    set_addr(16'h0000);
    for (int i = 0; i < 3; i++) fifo_read_check("R3 data kept");
    frame();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule